// File: doc/BRIEF.md
# Single-Line Configurable NMI Interrupt Controller

This block handles one external interrupt line, usually the non-maskable interrupt pin of a power-management device, and passes a qualified request on to a parent interrupt controller. The raw line first goes through a two-flop synchroniser. A detector then qualifies the synchronised level against one of four trigger modes, which software selects with a 2-bit code in a mode register.

A detected event sets a sticky pending flag. Software clears this flag by writing 1 to bit 0 of the pending register. The outgoing request is the pending flag gated by an enable bit. Software reads the pending register to tell a real event from a spurious one: it reads zero when nothing is latched.

All registers are accessed over a simple 32-bit single-cycle read/write bus. A parameter chooses one of three register placements:
- Default placement: mode at 0x00, pending at 0x04, enable at 0x08.
- Default placement with the enable register moved to 0x34.
- Alternate placement: mode at 0x0C, pending at 0x10, enable at 0x40.

Only source 0 exists.

Top module: `nmi_line_ctrl`

## Requirements
- R1: After reset, the mode, pending and enable registers all read 0 and `irq_o` is 0. Both synchroniser flops and the edge-history flop reset to 1, so a line held high through reset raises no event.
- R2: With `MAP_SEL`=0 the registers are at mode 0x00, pending 0x04 and enable 0x08. With `MAP_SEL`=1 the enable register moves to 0x34. With `MAP_SEL`=2 they are at mode 0x0C, pending 0x10 and enable 0x40. A read of any other address returns 0, and a write to any other address changes nothing.
- R3: The mode field is bits [1:0] of the mode register: 0 means low level, 1 falling edge, 2 high level, 3 rising edge. All other bits read as 0.
- R4: In the two edge modes, the pending bit sets on the selected edge. It then stays set, whatever the line does, until it is acknowledged.
- R5: In the two level modes, the pending bit sets while the active level is present. If the level is still active, it sets again right after an acknowledge. After an acknowledge with the level inactive, it stays clear.
- R6: A write to the pending register with bit 0 = 1 clears the pending bit; a write with bit 0 = 0 has no effect. A read of the pending register returns the pending bit in bit 0 and 0 in all other bits.
- R7: If an event is detected in the same cycle that an acknowledge write is captured, the pending bit stays set.
- R8: Only bit 0 of the enable register is stored; a write with bit 0 clear disables, whatever the other bits hold. `irq_o` equals pending AND enable.
- R9: A line change on `line_i` that forms an event sets pending on the third rising clock edge after the change: two synchroniser stages plus the pending flop.
- R10: Read data appears on `bus_rdata_o` one cycle after the read is requested, and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Asynchronous external interrupt line |
| bus_req_i | input | 1 | Bus access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Request to the parent controller |

## Verification
A corrupted mode register would make events appear on the wrong edge or level; this shows on `irq_o` three cycles after the line changes, and at once on a read-back of the mode register. A pending bit that is cleared wrongly, or one that fails to stick, shows at `irq_o` on the next cycle while the enable is set. An acknowledge racing an event shows on the next pending read. A reference model in the bench, stepped each clock, compares `irq_o` on every cycle and each read's data one cycle after the read is requested. Misdecoded addresses therefore show up within one access.

// File: rtl/nmi_line_pkg.sv
package nmi_line_pkg;

  typedef enum logic [1:0] {
    TRIG_LVL_LO    = 2'd0,
    TRIG_EDGE_FALL = 2'd1,
    TRIG_LVL_HI    = 2'd2,
    TRIG_EDGE_RISE = 2'd3
  } trig_e;

  typedef struct packed {
    logic [7:0] ctl;
    logic [7:0] pnd;
    logic [7:0] ena;
  } reg_map_t;

  function automatic reg_map_t map_of(input int sel);
    reg_map_t m;
    case (sel)
      1:       m = '{ctl: 8'h00, pnd: 8'h04, ena: 8'h34};
      2:       m = '{ctl: 8'h0C, pnd: 8'h10, ena: 8'h40};
      default: m = '{ctl: 8'h00, pnd: 8'h04, ena: 8'h08};
    endcase
    return m;
  endfunction

endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= RST_VAL;
        else         q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= {STAGES{RST_VAL}};
        else         q <= {q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/nmi_detect.sv
module nmi_detect
  import nmi_line_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  lvl_i,
  input  trig_e mode_i,
  output logic  evt_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= lvl_i;

  always_comb begin
    unique case (mode_i)
      TRIG_LVL_LO:    evt_o = ~lvl_i;
      TRIG_EDGE_FALL: evt_o = prev_q & ~lvl_i;
      TRIG_LVL_HI:    evt_o = lvl_i;
      TRIG_EDGE_RISE: evt_o = ~prev_q & lvl_i;
      default:        evt_o = 1'b0;
    endcase
  end

  // R4
  edge_needs_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o && (mode_i == TRIG_EDGE_RISE || mode_i == TRIG_EDGE_FALL)) |=> $changed(prev_q));
endmodule

// File: rtl/nmi_regs.sv
module nmi_regs
  import nmi_line_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int MAP_SEL = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              evt_i,
  output trig_e             mode_o,
  output logic              irq_o
);
  localparam reg_map_t MAP = map_of(MAP_SEL);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(MAP.ctl);
  localparam logic [ADDR_W-1:0] A_PND = ADDR_W'(MAP.pnd);
  localparam logic [ADDR_W-1:0] A_ENA = ADDR_W'(MAP.ena);

  trig_e             mode_q;
  logic              pend_q, en_q;
  logic [DATA_W-1:0] rdata_q, rd_val;
  logic              wr, rd, ack_wr;

  assign wr     = req_i & we_i;
  assign rd     = req_i & ~we_i;
  assign ack_wr = wr && addr_i == A_PND && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      mode_q <= TRIG_LVL_LO;
      en_q   <= 1'b0;
    end else if (wr) begin
      if (addr_i == A_CTL) mode_q <= trig_e'(wdata_i[1:0]);
      if (addr_i == A_ENA) en_q   <= wdata_i[0];
    end

  // new event outranks acknowledge
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     pend_q <= 1'b0;
    else if (evt_i)  pend_q <= 1'b1;
    else if (ack_wr) pend_q <= 1'b0;

  always_comb begin
    rd_val = '0;
    if (addr_i == A_CTL)      rd_val[1:0] = mode_q;
    else if (addr_i == A_PND) rd_val[0]   = pend_q;
    else if (addr_i == A_ENA) rd_val[0]   = en_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_val;

  assign rdata_o = rdata_q;
  assign mode_o  = mode_q;
  assign irq_o   = pend_q & en_q;

  // R7
  evt_beats_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && ack_wr) |=> pend_q);
  // R6
  ack_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_wr && !evt_i) |=> !pend_q);
  // R4
  pend_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !ack_wr) |=> pend_q);
  // R8
  disable_masks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == A_ENA && !wdata_i[0]) |=> !irq_o);
  // R10
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(rdata_o));
endmodule

// File: rtl/nmi_line_ctrl.sv
module nmi_line_ctrl
  import nmi_line_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int MAP_SEL    = 0,
  parameter int SYNC_STAGE = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_i,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              irq_o
);
  logic  line_s, evt;
  trig_e mode;

  nmi_sync #(.STAGES(SYNC_STAGE), .RST_VAL(1'b1)) i_sync (
    .clk_i, .rst_ni, .d_i(line_i), .q_o(line_s)
  );

  nmi_detect i_detect (
    .clk_i, .rst_ni, .lvl_i(line_s), .mode_i(mode), .evt_o(evt)
  );

  nmi_regs #(.ADDR_W(ADDR_W), .DATA_W(32), .MAP_SEL(MAP_SEL)) i_regs (
    .clk_i, .rst_ni,
    .req_i(bus_req_i), .we_i(bus_we_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o),
    .evt_i(evt), .mode_o(mode), .irq_o
  );
endmodule

// File: tb/test_nmi_line_ctrl.sv
module test_nmi_line_ctrl;
  localparam logic [7:0] A_CTL = 8'h00, A_PND = 8'h04, A_ENA = 8'h08, A_BAD = 8'h20;

  logic clk = 1'b0, rst_n = 1'b0, line = 1'b1;
  logic req = 1'b0, we = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq;
  logic a_req = 1'b0, a_we = 1'b0;
  logic [7:0] a_addr = '0;
  logic [31:0] a_wdata = '0, a_rdata;
  logic a_irq;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  nmi_line_ctrl #(.MAP_SEL(0)) i_nmi_line_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq));

  nmi_line_ctrl #(.MAP_SEL(2)) i_nmi_line_ctrl_alt (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .bus_req_i(a_req), .bus_we_i(a_we),
    .bus_addr_i(a_addr), .bus_wdata_i(a_wdata), .bus_rdata_o(a_rdata), .irq_o(a_irq));

  // reference model built from the requirements
  logic m_s1, m_s2, m_prev, m_pend, m_en;
  logic [1:0] m_ctl;
  logic [31:0] m_rd;

  function automatic logic f_evt(logic [1:0] c, logic s, logic p);
    case (c)
      2'd0: return !s;
      2'd1: return p && !s;
      2'd2: return s;
      default: return !p && s;
    endcase
  endfunction

  function automatic logic [31:0] f_rd(logic [7:0] a, logic [1:0] c, logic p, logic e);
    if (a == A_CTL) return {30'd0, c};
    if (a == A_PND) return {31'd0, p};
    if (a == A_ENA) return {31'd0, e};
    return 32'd0;
  endfunction

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      m_s1 <= 1'b1; m_s2 <= 1'b1; m_prev <= 1'b1;
      m_pend <= 1'b0; m_en <= 1'b0; m_ctl <= 2'd0; m_rd <= '0;
    end else begin
      m_s1 <= line; m_s2 <= m_s1; m_prev <= m_s2;
      if (f_evt(m_ctl, m_s2, m_prev)) m_pend <= 1'b1;
      else if (req && we && addr == A_PND && wdata[0]) m_pend <= 1'b0;
      if (req && we && addr == A_CTL) m_ctl <= wdata[1:0];
      if (req && we && addr == A_ENA) m_en <= wdata[0];
      if (req && !we) m_rd <= f_rd(addr, m_ctl, m_pend, m_en);
    end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // R8 R9: irq_o against model on every cycle
  always @(negedge clk) if (rst_n && !done) chk("R8/R9 irq", {31'd0, irq}, {31'd0, m_pend & m_en});

  task automatic wr(logic [7:0] a, logic [31:0] d);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    req = 1; we = 0; addr = a;
    @(negedge clk); req = 0; d = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    idle(3); rst_n = 1; idle(2);
    // R1
    rd(A_CTL, v); chk("R1 ctl", v, 0);
    rd(A_PND, v); chk("R1 pend", v, 0);
    rd(A_ENA, v); chk("R1 ena", v, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    // R2 unmapped
    wr(A_BAD, 32'hFFFF_FFFF); rd(A_BAD, v); chk("R2 unmapped", v, 0);
    // R3 R9: rising-edge latency
    line = 0; wr(A_CTL, 32'hFFFF_FFF3); wr(A_ENA, 1); idle(3); wr(A_PND, 1);
    rd(A_CTL, v); chk("R3 ctl readback", v, 3);
    line = 1;
    @(posedge clk); @(posedge clk); @(negedge clk); chk("R9 before", {31'd0, irq}, 0);
    @(posedge clk); @(negedge clk); chk("R9 third edge", {31'd0, irq}, 1);
    // R4 sticky after line drops
    line = 0; idle(5); rd(A_PND, v); chk("R4 sticky", v, 1);
    // R6
    wr(A_PND, 32'hFFFF_FFFE); rd(A_PND, v); chk("R6 bit0 clear no-op", v, 1);
    wr(A_PND, 1); rd(A_PND, v); chk("R6 ack", v, 0);
    // R7 event and ack in the same cycle
    idle(3); line = 1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    wr(A_PND, 1); rd(A_PND, v); chk("R7 event wins", v, 1);
    // R8
    wr(A_ENA, 32'hFFFF_FFFE); chk("R8 masked", {31'd0, irq}, 0);
    rd(A_ENA, v); chk("R8 ena bit0", v, 0);
    wr(A_ENA, 1); chk("R8 unmasked", {31'd0, irq}, 1);
    // R5 high level reasserts
    wr(A_CTL, 2); idle(4); wr(A_PND, 1); rd(A_PND, v); chk("R5 reassert", v, 1);
    line = 0; idle(4); wr(A_PND, 1); rd(A_PND, v); chk("R5 inactive", v, 0);
    // R3 low level and falling edge
    wr(A_CTL, 0); idle(4); rd(A_PND, v); chk("R3 low level", v, 1);
    line = 1; wr(A_CTL, 1); idle(4); wr(A_PND, 1); rd(A_PND, v); chk("R3 falling idle", v, 0);
    line = 0; idle(4); rd(A_PND, v); chk("R3 falling", v, 1);
    // R2 R10 alternate map
    a_req = 1; a_we = 1; a_addr = 8'h0C; a_wdata = 3; @(negedge clk);
    a_addr = 8'h40; a_wdata = 1; @(negedge clk);
    a_we = 0; a_addr = 8'h0C; @(negedge clk); chk("R2 alt ctl", a_rdata, 3);
    a_addr = 8'h40; @(negedge clk); chk("R2 alt ena", a_rdata, 1);
    a_addr = 8'h00; @(negedge clk); a_req = 0; chk("R2 alt old offset", a_rdata, 0);
    idle(2); chk("R10 hold", a_rdata, 0);
    // random phase, checked against the model
    for (int i = 0; i < 4000; i++) begin
      int op;
      logic [7:0] ra;
      if ($urandom_range(7) == 0) line = ~line;
      op = $urandom_range(9);
      case ($urandom_range(3))
        0: ra = A_CTL; 1: ra = A_PND; 2: ra = A_ENA; default: ra = A_BAD;
      endcase
      if (op < 3) wr(ra, $urandom);
      else if (op < 6) begin
        rd(ra, v); chk("R2/R3/R5/R6/R10 random read", v, m_rd);
      end else idle(1);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule